// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block is the device-side write path of a two-bank synchronous DRAM. It watches the command pins and recognises a WRITE. At that command it captures the bank, the starting column and the auto-precharge request. It then issues one write strobe per clock into the cell array, with a column address and a data word for each. The first word belongs to the edge that registers the WRITE command itself. After that, one word is written on each following edge until the burst is done.

Burst length and burst type come from static configuration inputs. Fixed bursts of 1, 2, 4 or 8 words stay inside an aligned column block. Within that block the column either counts up with wraparound or follows an XOR pattern. A full-page burst runs until a command stops it, and it rolls over from the last column back to column 0. A new WRITE may replace a running burst on any cycle. When an auto-precharge burst finishes normally, a one-cycle precharge request is raised for its bank.

Top module: `sdram_wr_seq`

## Requirements
- R1: A WRITE is cs_n=0, ras_n=1, cas_n=0, we_n=0 while cke=1. In that same cycle wr_en is 1, wr_col equals addr[7:0], wr_bank equals ba and wr_data equals dq.
- R2: addr[9:8] have no effect on the column or bank of a write.
- R3: With burst_intlv=0 and a fixed length L, word i goes to column (start & ~(L-1)) | ((start+i) & (L-1)).
- R4: With burst_intlv=1 and a fixed length L, word i goes to column (start & ~(L-1)) | ((start ^ i) & (L-1)).
- R5: The bl_code values 0, 1, 2 and 3 select 1, 2, 4 and 8 words; codes 4 to 6 act as one word. Once the last word is written, wr_en stays 0 and dq is ignored.
- R6: bl_code=7 selects a full-page burst. It is always sequential, runs past column 255 to column 0, and does not end by itself.
- R7: Any command that is neither NOP (cs_n=1, or ras_n=cas_n=we_n=1) nor WRITE, issued while cke=1, ends the running burst. No strobe is issued in that cycle.
- R8: A WRITE during a burst, to either bank, starts a new burst at once. The word given with it is written at the new bank and column.
- R9: If addr[10]=1 at the WRITE, then in the cycle after the last word of the burst pre_valid is 1 for exactly one cycle, with pre_bank set to the burst's bank.
- R10: No precharge request comes from a burst that had addr[10]=0, that was cut short by a WRITE or another command, or that ran in full-page mode.
- R11: While cke=0 no strobe is issued and commands are ignored. The burst resumes at the next column once cke returns to 1.
- R12: While rst_n=0 and right after reset, wr_en and pre_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; low suspends the sequencer |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Address: [7:0] column, [10] auto-precharge |
| ba | input | 1 | Bank select |
| dq | input | 16 | Write data |
| bl_code | input | 3 | Burst length code (static) |
| burst_intlv | input | 1 | 1 selects interleaved order (static) |
| wr_en | output | 1 | Array write strobe |
| wr_bank | output | 1 | Bank of the write |
| wr_col | output | 8 | Column of the write |
| wr_data | output | 16 | Data of the write |
| pre_valid | output | 1 | Auto-precharge request, one cycle |
| pre_bank | output | 1 | Bank to precharge |

## Verification
Sequential bursts start at an unaligned column so that the wrap inside the aligned block shows up. Interleaved bursts start at a column whose low bits are not zero, so the XOR order can be told apart from plain counting. Full-page bursts start two columns before the top of the page, which proves the roll-over to column 0. Other cases cover a WRITE arriving in the middle of a burst, a WRITE arriving right after a one-word burst, a precharge command in the middle of a burst, and cke dropping while a WRITE is on the pins. Together they separate a burst that completes, which raises pre_valid, from one that is abandoned, which does not, and show that a stalled burst resumes at the right column.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_OTHER = 2'd2
   } cmd_e;

   localparam logic [2:0] BL_FULL_PAGE = 3'b111;

   // Burst length code to column-offset mask (length minus one)
   function automatic logic [15:0] len_mask(input logic [2:0] code);
      case (code)
         3'd1:         len_mask = 16'h0001;
         3'd2:         len_mask = 16'h0003;
         3'd3:         len_mask = 16'h0007;
         BL_FULL_PAGE: len_mask = 16'hFFFF;
         default:      len_mask = 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_wr_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_NOP;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b100:  cmd = CMD_WRITE;
            default: cmd = CMD_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
   parameter int COL_W    = 8,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic [COL_W-1:0] start_col,
   input  logic [COL_W-1:0] idx,
   input  logic [COL_W-1:0] mask,
   input  logic             intlv,
   input  logic             full,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] seq_low;
   assign seq_low = (start_col + idx) & mask;

   generate
      if (INTLV_EN) begin : g_intlv
         logic [COL_W-1:0] xor_low;
         assign xor_low = (start_col ^ idx) & mask;
         assign col = (start_col & ~mask) | ((intlv && !full) ? xor_low : seq_low);
      end else begin : g_seq_only
         logic unused_mode;
         assign unused_mode = intlv & full;
         assign col = (start_col & ~mask) | seq_low;
      end
   endgenerate

endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
   import sdram_wr_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int BANK_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  cmd_e              cmd,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              cmd_ap,
   input  logic [COL_W-1:0]  mask,
   input  logic              full,
   output logic              strobe,
   output logic [COL_W-1:0]  cur_idx,
   output logic [COL_W-1:0]  cur_start,
   output logic [BANK_W-1:0] cur_bank,
   output logic              pre_valid,
   output logic [BANK_W-1:0] pre_bank
);

   logic              act_q;
   logic [COL_W-1:0]  cnt_q;
   logic [COL_W-1:0]  start_q;
   logic [BANK_W-1:0] bank_q;
   logic              ap_q;

   logic is_wr, kill, cur_ap, last;

   assign is_wr     = cke && (cmd == CMD_WRITE);
   assign kill      = cke && (cmd == CMD_OTHER);
   assign strobe    = rst_n && (is_wr || (cke && act_q && !kill));
   assign cur_idx   = is_wr ? '0 : cnt_q;
   assign cur_start = is_wr ? cmd_col : start_q;
   assign cur_bank  = is_wr ? cmd_bank : bank_q;
   assign cur_ap    = is_wr ? cmd_ap : ap_q;
   assign last      = strobe && !full && (cur_idx == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         cnt_q     <= '0;
         start_q   <= '0;
         bank_q    <= '0;
         ap_q      <= 1'b0;
         pre_valid <= 1'b0;
         pre_bank  <= '0;
      end else begin
         pre_valid <= last && cur_ap;
         if (last && cur_ap) pre_bank <= cur_bank;
         if (cke) begin
            if (strobe) begin
               act_q   <= !last;
               cnt_q   <= cur_idx + COL_W'(1);
               start_q <= cur_start;
               bank_q  <= cur_bank;
               ap_q    <= cur_ap;
            end else if (kill) begin
               act_q <= 1'b0;
            end
         end
      end
   end

   // R9
   pre_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_valid |-> $past(strobe));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(cnt_q) && $stable(act_q) && $stable(bank_q)));

   // R5
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !full) |-> (cnt_q <= mask));

   // R8
   bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !is_wr) |-> (cur_bank == $past(cur_bank)));

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
   import sdram_wr_pkg::*;
#(
   parameter int COL_W    = 8,
   parameter int BANK_W   = 1,
   parameter int ADDR_W   = 11,
   parameter int AP_BIT   = 10,
   parameter int DATA_W   = 16,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] ba,
   input  logic [DATA_W-1:0] dq,
   input  logic [2:0]        bl_code,
   input  logic              burst_intlv,
   output logic              wr_en,
   output logic [BANK_W-1:0] wr_bank,
   output logic [COL_W-1:0]  wr_col,
   output logic [DATA_W-1:0] wr_data,
   output logic              pre_valid,
   output logic [BANK_W-1:0] pre_bank
);

   generate
      if (COL_W < 3 || COL_W > 16) begin : g_bad_col
         $error("COL_W must lie in 3..16");
      end
      if (AP_BIT < COL_W || AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("AP_BIT must sit above the column field and inside addr");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("BANK_W must be at least 1");
      end
   endgenerate

   cmd_e             cmd;
   logic [15:0]      mask_full;
   logic [COL_W-1:0] mask;
   logic             full;
   logic [COL_W-1:0] cur_idx, cur_start;

   assign mask_full = len_mask(bl_code);
   assign mask      = mask_full[COL_W-1:0];
   assign full      = (bl_code == BL_FULL_PAGE);
   assign wr_data   = dq;

   sdram_cmd_decode i_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   sdram_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke       (cke),
      .cmd       (cmd),
      .cmd_col   (addr[COL_W-1:0]),
      .cmd_bank  (ba),
      .cmd_ap    (addr[AP_BIT]),
      .mask      (mask),
      .full      (full),
      .strobe    (wr_en),
      .cur_idx   (cur_idx),
      .cur_start (cur_start),
      .cur_bank  (wr_bank),
      .pre_valid (pre_valid),
      .pre_bank  (pre_bank)
   );

   sdram_col_gen #(.COL_W(COL_W), .INTLV_EN(INTLV_EN)) i_col (
      .start_col (cur_start),
      .idx       (cur_idx),
      .mask      (mask),
      .intlv     (burst_intlv),
      .full      (full),
      .col       (wr_col)
   );

   // R1
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cmd == CMD_WRITE) |-> (wr_en && wr_col == addr[COL_W-1:0] && wr_bank == ba));

   // R6
   page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && $past(wr_en) && cmd != CMD_WRITE)
         |-> (wr_col == $past(wr_col) + COL_W'(1)));

   // R7
   kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cmd == CMD_OTHER) |-> !wr_en);

endmodule

// File: tb/test_sdram_wr_seq.sv
`timescale 1ns/1ps
module test_sdram_wr_seq;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_PRE = 4'b0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [10:0] addr = '0;
   logic [0:0]  ba = '0;
   logic [15:0] dq = '0;
   logic [2:0]  bl_code = 3'd2;
   logic        burst_intlv = 1'b0;
   logic        wr_en, pre_valid;
   logic [0:0]  wr_bank, pre_bank;
   logic [7:0]  wr_col;
   logic [15:0] wr_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sdram_wr_seq i_sdram_wr_seq (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .dq(dq),
      .bl_code(bl_code), .burst_intlv(burst_intlv), .wr_en(wr_en),
      .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
      .pre_valid(pre_valid), .pre_bank(pre_bank)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive one cycle at the falling edge and settle before sampling
   task automatic cyc(input logic [3:0] c, input logic [10:0] a,
                      input logic b, input logic [15:0] d, input logic k = 1'b1);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      addr = a; ba = b; dq = d; cke = k;
      #2;
   endtask

   function automatic logic [7:0] exp_col(input logic [7:0] s, input int i,
                                          input int len, input logic ilv);
      logic [7:0] m, lo;
      m  = 8'(len - 1);
      lo = ilv ? ((s ^ 8'(i)) & m) : ((s + 8'(i)) & m);
      return (s & ~m) | lo;
   endfunction

   task automatic expect_wr(input string req, input logic [7:0] col,
                            input logic b, input logic [15:0] d);
      check(req, "wr_en", wr_en, 1);
      check(req, "wr_col", wr_col, col);
      check(req, "wr_bank", wr_bank, b);
      check(req, "wr_data", wr_data, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(C_NOP, 11'h0, 1'b0, 16'h0);
   endtask

   task automatic t_reset();
      check("R12", "wr_en in reset", wr_en, 0);
      check("R12", "pre_valid in reset", pre_valid, 0);
      @(negedge clk); rst_n = 1'b1;
      cyc(C_NOP, 11'h0, 1'b0, 16'h0);
      check("R12", "wr_en after reset", wr_en, 0);
      check("R12", "pre_valid after reset", pre_valid, 0);
   endtask

   task automatic t_seq4();
      bl_code = 3'd2; burst_intlv = 1'b0;
      // addr[9:8]=11 must not matter (R2)
      cyc(C_WR, 11'h30D, 1'b0, 16'hA000);
      expect_wr("R1_R2", 8'h0D, 1'b0, 16'hA000);
      for (int i = 1; i < 4; i++) begin
         cyc(C_NOP, 11'h0, 1'b0, 16'hA000 + 16'(i));
         expect_wr("R3", exp_col(8'h0D, i, 4, 1'b0), 1'b0, 16'hA000 + 16'(i));
      end
      cyc(C_NOP, 11'h0, 1'b0, 16'hBEEF);
      check("R5", "wr_en after last word", wr_en, 0);
      check("R10", "pre_valid without A10", pre_valid, 0);
      idle(1);
   endtask

   task automatic t_intl8();
      bl_code = 3'd3; burst_intlv = 1'b1;
      cyc(C_WR, 11'h435, 1'b1, 16'hC000);
      expect_wr("R4", 8'h35, 1'b1, 16'hC000);
      for (int i = 1; i < 8; i++) begin
         cyc(C_NOP, 11'h0, 1'b0, 16'hC000 + 16'(i));
         expect_wr("R4", exp_col(8'h35, i, 8, 1'b1), 1'b1, 16'hC000 + 16'(i));
      end
      cyc(C_NOP, 11'h0, 1'b0, 16'h0);
      check("R5", "wr_en after 8 words", wr_en, 0);
      check("R9", "pre_valid", pre_valid, 1);
      check("R9", "pre_bank", pre_bank, 1);
      cyc(C_NOP, 11'h0, 1'b0, 16'h0);
      check("R9", "pre_valid one cycle", pre_valid, 0);
      idle(1);
   endtask

   task automatic t_len1_and_2();
      bl_code = 3'd0; burst_intlv = 1'b0;
      cyc(C_WR, 11'h440, 1'b0, 16'h1111);
      expect_wr("R5", 8'h40, 1'b0, 16'h1111);
      cyc(C_WR, 11'h041, 1'b1, 16'h2222);
      expect_wr("R8", 8'h41, 1'b1, 16'h2222);
      check("R9", "pre_valid after 1-word burst", pre_valid, 1);
      check("R9", "pre_bank after 1-word burst", pre_bank, 0);
      cyc(C_NOP, 11'h0, 1'b0, 16'h3333);
      check("R5", "wr_en after 1-word burst", wr_en, 0);
      check("R10", "pre_valid with A10 low", pre_valid, 0);
      bl_code = 3'd1;
      cyc(C_WR, 11'h007, 1'b0, 16'h4444);
      expect_wr("R3", 8'h07, 1'b0, 16'h4444);
      cyc(C_NOP, 11'h0, 1'b0, 16'h5555);
      expect_wr("R3", 8'h06, 1'b0, 16'h5555);
      cyc(C_NOP, 11'h0, 1'b0, 16'h6666);
      check("R5", "wr_en after 2-word burst", wr_en, 0);
      idle(1);
   endtask

   task automatic t_trunc();
      bl_code = 3'd3; burst_intlv = 1'b0;
      cyc(C_WR, 11'h410, 1'b0, 16'h7000);
      expect_wr("R3", 8'h10, 1'b0, 16'h7000);
      cyc(C_NOP, 11'h0, 1'b0, 16'h7001);
      expect_wr("R3", 8'h11, 1'b0, 16'h7001);
      cyc(C_WR, 11'h080, 1'b1, 16'h8000);
      expect_wr("R8", 8'h80, 1'b1, 16'h8000);
      for (int i = 1; i < 8; i++) begin
         cyc(C_NOP, 11'h0, 1'b0, 16'h8000 + 16'(i));
         expect_wr("R8", 8'h80 + 8'(i), 1'b1, 16'h8000 + 16'(i));
         check("R10", "pre_valid from cut burst", pre_valid, 0);
      end
      cyc(C_NOP, 11'h0, 1'b0, 16'h0);
      check("R5", "wr_en after new burst", wr_en, 0);
      check("R10", "pre_valid after new burst", pre_valid, 0);
      idle(1);
   endtask

   task automatic t_full();
      bl_code = 3'd7; burst_intlv = 1'b1;
      cyc(C_WR, 11'h4FE, 1'b1, 16'h9000);
      expect_wr("R6", 8'hFE, 1'b1, 16'h9000);
      for (int i = 1; i < 6; i++) begin
         cyc(C_NOP, 11'h0, 1'b0, 16'h9000 + 16'(i));
         expect_wr("R6", 8'hFE + 8'(i), 1'b1, 16'h9000 + 16'(i));
      end
      cyc(C_PRE, 11'h0, 1'b0, 16'h9999);
      check("R7", "wr_en at precharge", wr_en, 0);
      cyc(C_NOP, 11'h0, 1'b0, 16'h9999);
      check("R7", "wr_en after precharge", wr_en, 0);
      check("R10", "pre_valid for full page", pre_valid, 0);
      idle(1);
   endtask

   task automatic t_fixed_kill();
      bl_code = 3'd2; burst_intlv = 1'b0;
      cyc(C_WR, 11'h430, 1'b0, 16'hD000);
      expect_wr("R1", 8'h30, 1'b0, 16'hD000);
      cyc(C_PRE, 11'h0, 1'b0, 16'hD001);
      check("R7", "wr_en at precharge", wr_en, 0);
      for (int i = 0; i < 4; i++) begin
         cyc(C_NOP, 11'h0, 1'b0, 16'hD002);
         check("R7", "wr_en after kill", wr_en, 0);
         check("R10", "pre_valid after kill", pre_valid, 0);
      end
   endtask

   task automatic t_cke();
      bl_code = 3'd2; burst_intlv = 1'b0;
      cyc(C_WR, 11'h020, 1'b0, 16'hE000);
      expect_wr("R1", 8'h20, 1'b0, 16'hE000);
      cyc(C_NOP, 11'h0, 1'b0, 16'hE001);
      expect_wr("R11", 8'h21, 1'b0, 16'hE001);
      cyc(C_WR, 11'h055, 1'b1, 16'hEEEE, 1'b0);
      check("R11", "wr_en with cke low", wr_en, 0);
      cyc(C_NOP, 11'h0, 1'b0, 16'hE002);
      expect_wr("R11", 8'h22, 1'b0, 16'hE002);
      cyc(C_NOP, 11'h0, 1'b0, 16'hE003);
      expect_wr("R11", 8'h23, 1'b0, 16'hE003);
      cyc(C_NOP, 11'h0, 1'b0, 16'h0);
      check("R11", "wr_en after resumed burst", wr_en, 0);
      idle(1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #20;
      t_reset();
      t_seq4();
      t_intl8();
      t_len1_and_2();
      t_trunc();
      t_full();
      t_fixed_kill();
      t_cke();
      finish_run();
   end

endmodule